// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Gate Controller

This block drives the nine gate signals of a 19-level asymmetrical inverter bridge. It has five unit switches (S1 to S5, where S5 is the shared capacitor-charging switch) and four polarity switches (T1 to T4). It builds its own sampled sinusoidal reference and a stack of eighteen identical triangular carriers. Each clock it counts how many carriers the reference lies strictly above. Subtracting nine from that count gives a signed level from -9 to +9. A small state machine then picks the polarity state and turns the level into gate bits.

The zero level has two switching states, 0+ and 0-. Both close S1, S3 and S5 so that the capacitors recharge. The machine alternates between the two zero states on successive entries into zero, and a status output shows which one is active. A modulation index input scales the reference. With a full-scale index of 0.5, the reference reaches only ten carriers and the output narrows to 11 levels.

The state machine has five states:
- OFF: disabled or in reset.
- POS: positive level.
- NEG: negative level.
- ZPLUS: zero state 0+.
- ZMINUS: zero state 0-.

The transitions are:
- Any state goes to OFF when `enable` is low.
- OFF goes to ZPLUS on the first enabled cycle.
- A positive next level goes to POS, and a negative next level goes to NEG.
- A zero next level holds ZPLUS or ZMINUS when the machine is already in one of them.
- A zero next level reached from POS or NEG goes to the zero state that was not used last time.

Top module: `mlpwm_gate_ctrl`

## Requirements
- R1: While reset is asserted, and one clock edge after `enable` is seen low, all gates are low, `level` is 0 and `zero_minus` is 0.
- R2: On the first clock edge with `enable` high after a disabled cycle, `level` becomes 0 and the 0+ zero state is entered. All internal counters restart at zero, which is a carrier period boundary.
- R3: The carrier phase is t mod CAR_PERIOD, where t counts enabled edges since the restart. The triangle value is c = phase for phase <= CAR_PERIOD/2, and CAR_PERIOD - phase otherwise. With band height A = CAR_PERIOD/2, carrier k (k = 0..17) equals (k-9)*A + c.
- R4: The reference sample index is (t / SAMPLE_DIV) mod SAMPLES. With H = SAMPLES/2 and q = index mod H, the reference is sign * floor(9*A*m*4*q*(H-q) / (128*H*H)). The sign is negative when index >= H.
- R5: The next level equals the number of carriers that the reference strictly exceeds, minus 9. A reference equal to a carrier counts as below it. The level output updates one edge after the counter state it was computed from.
- R6: `unit_gate` bit i drives S(i+1). For level magnitudes 9 down to 1, the bits S1..S5 are 11110, 11100, 11000, 01110, 01100, 10101, 10100, 00110 and 00100.
- R7: For a positive level, `pol_gate` = {T4,T3,T2,T1} = 0101. For a negative level it is 1010.
- R8: Both zero states set S1..S5 = 10101 and {T4,T3,T2,T1} = 0011. Entering zero from POS or NEG picks the zero state not used at the previous entry. `zero_minus` is high only in 0-.
- R9: S5 is on only at levels +4, -4 and 0.
- R10: The modulation index m uses 128 as 1.0, and values above 128 behave as 128. At m = 64 the level magnitude peaks at 5, giving 11 levels.
- R11: `level` always stays within -9..+9, and at m = 128 it reaches both +9 and -9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the modulator; low forces all gates off |
| mod_index | input | MOD_W | Modulation index, 128 = 1.0, saturates above 128 |
| unit_gate | output | 5 | Gates S1..S5 (bit 0 = S1) |
| pol_gate | output | 4 | Gates T1..T4 (bit 0 = T1) |
| level | output | 5 | Signed output level, -9..+9 |
| zero_minus | output | 1 | High while the 0- zero state is active |

## Verification
The assertions check the following on every cycle:
- the level range;
- the polarity pattern for the sign of the level;
- S5 appearing only at zero or magnitude four;
- the gate pattern shared by the two zero states;
- all gates being low after a disabled cycle;
- the 0+ start after enable rises.

Other behaviour can only be shown by the bench's scenarios against a cycle-exact model. This includes the exact level sequence produced by the carrier and reference timing, the tie rule at a carrier peak, the alternation of zero states, and the narrowing to 11 levels at half index or the saturation of a large index.

// File: rtl/mlpwm_pkg.sv
`timescale 1ns/1ps
package mlpwm_pkg;

    localparam int NBAND = 9;
    localparam int LVL_W = 5;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_POS,
        ST_ZPLUS,
        ST_ZMINUS,
        ST_NEG
    } gstate_t;

    localparam logic [3:0] POL_POS  = 4'b0101;
    localparam logic [3:0] POL_NEG  = 4'b1010;
    localparam logic [3:0] POL_ZERO = 4'b0011;
    localparam logic [4:0] UNIT_ZERO = 5'b10101;

    // bit 0 = S1 ... bit 4 = S5
    function automatic logic [4:0] unit_pattern(input logic [3:0] mag);
        logic [4:0] u;
        case (mag)
            4'd9:    u = 5'b01111;
            4'd8:    u = 5'b00111;
            4'd7:    u = 5'b00011;
            4'd6:    u = 5'b01110;
            4'd5:    u = 5'b00110;
            4'd4:    u = 5'b10101;
            4'd3:    u = 5'b00101;
            4'd2:    u = 5'b01100;
            4'd1:    u = 5'b00100;
            default: u = UNIT_ZERO;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/mlpwm_timebase.sv
`timescale 1ns/1ps
module mlpwm_timebase #(
    parameter int CAR_PERIOD = 20000,
    parameter int SAMPLE_DIV = 10000,
    parameter int SAMPLES    = 200,
    localparam int CW = $clog2(CAR_PERIOD + 1),
    localparam int SW = $clog2(SAMPLE_DIV + 1),
    localparam int PW = $clog2(SAMPLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] tri_v,
    output logic [PW-1:0] phase
);
    localparam int HALF = CAR_PERIOD / 2;

    logic [CW-1:0] car_cnt;
    logic [SW-1:0] smp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_cnt <= '0;
            smp_cnt <= '0;
            phase   <= '0;
        end else if (!run) begin
            car_cnt <= '0;
            smp_cnt <= '0;
            phase   <= '0;
        end else begin
            car_cnt <= (car_cnt == CW'(CAR_PERIOD - 1)) ? '0 : car_cnt + 1'b1;
            if (smp_cnt == SW'(SAMPLE_DIV - 1)) begin
                smp_cnt <= '0;
                phase   <= (phase == PW'(SAMPLES - 1)) ? '0 : phase + 1'b1;
            end else begin
                smp_cnt <= smp_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        tri_v = (car_cnt <= CW'(HALF)) ? car_cnt : CW'(CAR_PERIOD) - car_cnt;
    end

endmodule

// File: rtl/mlpwm_refgen.sv
`timescale 1ns/1ps
module mlpwm_refgen #(
    parameter int AMP     = 10000,
    parameter int SAMPLES = 200,
    parameter int MOD_W   = 8,
    parameter int PW      = 8,
    parameter int RW      = 19
) (
    input  logic [PW-1:0]       phase,
    input  logic [MOD_W-1:0]    mod_index,
    output logic signed [RW-1:0] refv
);
    import mlpwm_pkg::*;

    localparam longint HN   = longint'(SAMPLES / 2);
    localparam longint FS   = longint'(NBAND * AMP);
    localparam longint FULL = longint'(2 ** (MOD_W - 1));

    always_comb begin
        longint p, q, meff, num, mag;
        logic neg;
        p    = longint'(phase);
        neg  = (p >= HN);
        q    = neg ? p - HN : p;
        meff = (longint'(mod_index) > FULL) ? FULL : longint'(mod_index);
        num  = FS * meff * 4 * q * (HN - q);
        mag  = num / (FULL * HN * HN);
        refv = RW'(neg ? -mag : mag);
    end

endmodule

// File: rtl/mlpwm_cmpbank.sv
`timescale 1ns/1ps
module mlpwm_cmpbank #(
    parameter int AMP = 10000,
    parameter int CW  = 15,
    parameter int RW  = 19
) (
    input  logic [CW-1:0]        tri_v,
    input  logic signed [RW-1:0] refv,
    output logic signed [mlpwm_pkg::LVL_W-1:0] level_nxt
);
    import mlpwm_pkg::*;

    localparam int NCAR = 2 * NBAND;

    logic [NCAR-1:0] hit;

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        localparam int BASE = (k - NBAND) * AMP;
        assign hit[k] = (int'(refv) > (BASE + int'({1'b0, tri_v})));
    end

    always_comb begin
        level_nxt = LVL_W'($countones(hit) - NBAND);
    end

endmodule

// File: rtl/mlpwm_gate_ctrl.sv
`timescale 1ns/1ps
module mlpwm_gate_ctrl #(
    parameter int CAR_PERIOD = 20000,
    parameter int SAMPLE_DIV = 10000,
    parameter int SAMPLES    = 200,
    parameter int MOD_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [MOD_W-1:0] mod_index,
    output logic [4:0]       unit_gate,
    output logic [3:0]       pol_gate,
    output logic signed [4:0] level,
    output logic             zero_minus
);
    import mlpwm_pkg::*;

    localparam int AMP = CAR_PERIOD / 2;
    localparam int CW  = $clog2(CAR_PERIOD + 1);
    localparam int PW  = $clog2(SAMPLES + 1);
    localparam int RW  = $clog2(NBAND * AMP + 1) + 2;

    logic [CW-1:0]        tri_v;
    logic [PW-1:0]        phase;
    logic signed [RW-1:0] refv;
    logic signed [LVL_W-1:0] level_nxt;

    gstate_t state_q, state_d;
    logic    last_minus_q;
    logic signed [LVL_W-1:0] level_q;
    logic [3:0] mag;

    mlpwm_timebase #(
        .CAR_PERIOD(CAR_PERIOD), .SAMPLE_DIV(SAMPLE_DIV), .SAMPLES(SAMPLES)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .run(enable), .tri_v(tri_v), .phase(phase)
    );

    mlpwm_refgen #(
        .AMP(AMP), .SAMPLES(SAMPLES), .MOD_W(MOD_W), .PW(PW), .RW(RW)
    ) u_ref (
        .phase(phase), .mod_index(mod_index), .refv(refv)
    );

    mlpwm_cmpbank #(.AMP(AMP), .CW(CW), .RW(RW)) u_cmp (
        .tri_v(tri_v), .refv(refv), .level_nxt(level_nxt)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else if (level_nxt > 0) begin
            state_d = ST_POS;
        end else if (level_nxt < 0) begin
            state_d = ST_NEG;
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_ZPLUS;
                ST_ZPLUS:  state_d = ST_ZPLUS;
                ST_ZMINUS: state_d = ST_ZMINUS;
                ST_POS,
                ST_NEG:    state_d = last_minus_q ? ST_ZPLUS : ST_ZMINUS;
                default:   state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_OFF;
            last_minus_q <= 1'b0;
            level_q      <= '0;
        end else begin
            state_q <= state_d;
            level_q <= enable ? level_nxt : '0;
            if (state_d == ST_ZPLUS)  last_minus_q <= 1'b0;
            if (state_d == ST_ZMINUS) last_minus_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        mag        = level_q[LVL_W-1] ? 4'(-level_q) : 4'(level_q);
        unit_gate  = '0;
        pol_gate   = '0;
        zero_minus = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                unit_gate = '0;
                pol_gate  = '0;
            end
            ST_POS: begin
                unit_gate = unit_pattern(mag);
                pol_gate  = POL_POS;
            end
            ST_NEG: begin
                unit_gate = unit_pattern(mag);
                pol_gate  = POL_NEG;
            end
            ST_ZPLUS: begin
                unit_gate = UNIT_ZERO;
                pol_gate  = POL_ZERO;
            end
            ST_ZMINUS: begin
                unit_gate  = UNIT_ZERO;
                pol_gate   = POL_ZERO;
                zero_minus = 1'b1;
            end
            default: begin
                unit_gate = '0;
                pol_gate  = '0;
            end
        endcase
    end

    assign level = level_q;

endmodule

// File: rtl/mlpwm_gate_ctrl_chk.sv
`timescale 1ns/1ps
module mlpwm_gate_ctrl_chk (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [4:0]        unit_gate,
    input logic [3:0]        pol_gate,
    input logic signed [4:0] level,
    input logic              zero_minus
);
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (unit_gate == 5'b0 && pol_gate == 4'b0 && level == 0 && !zero_minus));

    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |=> (level == 0 && !zero_minus && pol_gate == 4'b0011));

    a_r7_pos_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (level > 0) |-> (pol_gate == 4'b0101));

    a_r7_neg_pol: assert property (@(posedge clk) disable iff (!rst_n)
        (level < 0) |-> (pol_gate == 4'b1010));

    a_r8_zero_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        zero_minus |-> (level == 0 && pol_gate == 4'b0011 && unit_gate == 5'b10101));

    a_r9_charge_switch: assert property (@(posedge clk) disable iff (!rst_n)
        unit_gate[4] |-> (level == 0 || level == 4 || level == -4));

    a_r11_range: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= 9 && level >= -9));
endmodule

bind mlpwm_gate_ctrl mlpwm_gate_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .unit_gate(unit_gate),
    .pol_gate(pol_gate), .level(level), .zero_minus(zero_minus)
);

// File: tb/mlpwm_gate_ctrl_test.sv
`timescale 1ns/1ps
module mlpwm_gate_ctrl_test;
    localparam int P  = 20;
    localparam int SD = 10;
    localparam int N  = 20;
    localparam int A  = P / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [7:0] mod_index = 8'd128;
    logic [4:0] unit_gate;
    logic [3:0] pol_gate;
    logic signed [4:0] level;
    logic zero_minus;

    mlpwm_gate_ctrl #(.CAR_PERIOD(P), .SAMPLE_DIV(SD), .SAMPLES(N), .MOD_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mod_index(mod_index),
        .unit_gate(unit_gate), .pol_gate(pol_gate), .level(level), .zero_minus(zero_minus)
    );

    always #5 clk = ~clk;

    typedef struct {
        int         lvl;
        logic [4:0] unit;
        logic [3:0] pol;
        logic       zm;
        string      tag;
    } item_t;

    item_t sbq[$];
    int n_cmp = 0;
    int n_bad = 0;
    int max_abs = 0;
    int min_lvl = 0;
    int max_lvl = 0;

    // model state
    int   mt = 0;
    int   ms = 0;   // 0 off,1 pos,2 z+,3 z-,4 neg
    logic mlast_minus = 1'b0;

    function automatic int exp_level(int t, int m);
        int c, tv, ph, q, hn, cnt;
        longint meff, mag, refm;
        bit neg;
        c  = t % P;
        tv = (c <= P / 2) ? c : P - c;
        ph = (t / SD) % N;
        hn = N / 2;
        neg = (ph >= hn);
        q  = neg ? ph - hn : ph;
        meff = (m > 128) ? 128 : m;
        mag = (longint'(9 * A) * meff * 4 * q * (hn - q)) / (128 * hn * hn);
        refm = neg ? -mag : mag;
        cnt = 0;
        for (int k = 0; k < 18; k++)
            if (refm > longint'((k - 9) * A + tv)) cnt++;
        return cnt - 9;
    endfunction

    function automatic logic [4:0] exp_unit(int lvl);
        int a;
        a = (lvl < 0) ? -lvl : lvl;
        case (a)   // R6 table, bit0 = S1
            9: return 5'b01111;
            8: return 5'b00111;
            7: return 5'b00011;
            6: return 5'b01110;
            5: return 5'b00110;
            4: return 5'b10101;
            3: return 5'b00101;
            2: return 5'b01100;
            1: return 5'b00100;
            default: return 5'b10101;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: sets inputs at the falling edge, pushes the expected result
    task automatic step(bit en, int m, string tag);
        item_t it;
        int lvl;
        @(negedge clk);
        enable = en;
        mod_index = 8'(m);
        it.tag = tag;
        if (!en) begin
            ms = 0; mt = 0;
            it.lvl = 0; it.unit = 5'b0; it.pol = 4'b0; it.zm = 1'b0;
        end else begin
            lvl = exp_level(mt, m);
            mt++;
            if (lvl > 0) ms = 1;
            else if (lvl < 0) ms = 4;
            else if (ms == 0) ms = 2;
            else if (ms == 1 || ms == 4) ms = mlast_minus ? 2 : 3;
            if (ms == 2) mlast_minus = 1'b0;
            if (ms == 3) mlast_minus = 1'b1;
            it.lvl  = lvl;
            it.unit = exp_unit(lvl);
            it.pol  = (lvl > 0) ? 4'b0101 : (lvl < 0) ? 4'b1010 : 4'b0011;
            it.zm   = (ms == 3);
        end
        sbq.push_back(it);
        @(posedge clk);
    endtask

    // monitor
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            item_t e;
            int a;
            e = sbq.pop_front();
            check({e.tag, " level"}, int'(level), e.lvl);
            check({e.tag, " unit_gate"}, int'(unit_gate), int'(e.unit));
            check({e.tag, " pol_gate"}, int'(pol_gate), int'(e.pol));
            check({e.tag, " zero_minus"}, int'(zero_minus), int'(e.zm));
            a = (level < 0) ? -int'(level) : int'(level);
            if (a > max_abs) max_abs = a;
            if (int'(level) > max_lvl) max_lvl = int'(level);
            if (int'(level) < min_lvl) min_lvl = int'(level);
        end
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset unit_gate", int'(unit_gate), 0);
        check("R1 reset pol_gate", int'(pol_gate), 0);
        check("R1 reset level", int'(level), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 128, "R1 disabled");
        step(1'b0, 128, "R1 disabled");

        // first enabled edge: level 0, state 0+
        step(1'b1, 128, "R2 start");
        for (int i = 1; i < 2 * P * SD; i++) begin
            if (mt == 50) begin
                step(1'b1, 128, "R5 tie at peak");
                #2;
                check("R5 tie counts below", int'(level), 8);
            end else begin
                step(1'b1, 128, "R3 R4 R6 R7 R8 R9 full index");
            end
        end
        check("R11 reaches +9", max_lvl, 9);
        check("R11 reaches -9", min_lvl, -9);

        // disable mid-run, then restart at a boundary
        step(1'b0, 128, "R1 disable mid-run");
        step(1'b0, 128, "R1 disabled");
        step(1'b1, 64, "R2 restart");
        max_abs = 0;
        for (int i = 1; i < N * SD; i++) step(1'b1, 64, "R10 half index");
        check("R10 half index peak magnitude", max_abs, 5);

        // saturation: 200 behaves as 128
        step(1'b0, 200, "R1 disabled");
        step(1'b1, 200, "R2 restart");
        max_abs = 0;
        for (int i = 1; i < N * SD; i++) step(1'b1, 200, "R10 saturated index R8");
        check("R10 saturated peak magnitude", max_abs, 9);

        // change index on the fly
        for (int i = 0; i < N * SD; i++) step(1'b1, (i % 37) * 5, "R4 R5 varying index");
        step(1'b0, 0, "R1 final disable");
        @(posedge clk);
        #3;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule